// File: doc/BRIEF.md
# Multidrop Serial Receiver with Sleep and Wakeup

This block receives asynchronous serial characters on a single line shared by several nodes. A tick enable at sixteen times the baud rate paces it. The first falling edge qualifies a start bit. Every bit of the frame is then sampled three times around its centre, and the majority of the three samples gives the bit value. Each finished character goes to a data holding register. Status flags report data ready, an idle line, overrun, noise (samples that disagree) and framing error. A read acknowledge strobe clears the flags.

To skip messages meant for other nodes, software pulses a sleep request. While asleep the receiver raises no status flag. It wakes by itself in one of two ways, chosen by an input. In idle-line mode it wakes once the line has been high for one full character time. In address-mark mode it wakes when a character arrives whose top data bit is set, and it delivers that character.

Top module: `mdrop_rx`

## Requirements
- R1: Each bit value is the majority of the line samples taken at RT ticks 8, 9 and 10, where RT tick 1 is the first tick of the bit. A single disagreeing sample does not change the bit.
- R2: A frame is one start bit (0), then data bits least significant first, then one stop bit. There are 8 data bits when `frame_ext`=0 and 9 when `frame_ext`=1. Each bit lasts 16 RT ticks. When a frame finishes, the data goes to `rx_data` and `data_ready` sets. In 8-bit frames, `rx_data[8]` reads 0.
- R3: A start bit is qualified only by a high-to-low change between two RT samples. If the voted start bit is 1, no character is reported.
- R4: If the three samples of any bit in a delivered character disagree, `noise_err` sets together with `data_ready`.
- R5: If the voted stop bit is 0, `frame_err` sets and the data is still delivered with `data_ready`.
- R6: If a character finishes while `data_ready` is still 1, `overrun` sets and the new character is dropped. `rx_data` keeps the older one.
- R7: A pulse on `read_ack` clears `data_ready`, `overrun`, `noise_err`, `frame_err` and `idle_flag`.
- R8: `idle_flag` sets once after the line has been high for a full character time (160 RT ticks for 8-bit frames, 176 for 9-bit frames), but only after at least one character was delivered. It does not set again until another character is delivered. It never sets after reset before any character.
- R9: A pulse on `sleep_req` makes `sleeping` 1 on the next cycle. While `sleeping` stays 1, no status flag sets.
- R10: With `wake_mark`=0, `sleeping` clears after 160 (8-bit) or 176 (9-bit) consecutive high RT samples. The count starts from the `sleep_req` pulse or from the last low sample. This wakeup does not set `idle_flag`.
- R11: With `wake_mark`=1, a character whose top data bit is 1 clears `sleeping` and is delivered with `data_ready`. The top data bit is bit 7 for 8-bit frames and bit 8 for 9-bit frames. A character whose top bit is 0 is dropped, and the receiver stays asleep. In idle-line mode, every character received while asleep is dropped.
- R12: After reset, `rx_data` is 0 and every flag, including `sleeping`, is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rt_tick | input | 1 | One-cycle enable at 16x the baud rate |
| rxd | input | 1 | Serial line, asynchronous, idles high |
| frame_ext | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wake_mark | input | 1 | 1 selects address-mark wakeup, 0 selects idle-line wakeup |
| sleep_req | input | 1 | Strobe that puts the receiver to sleep |
| read_ack | input | 1 | Strobe that clears the status flags |
| rx_data | output | DATA_BITS+1 | Last delivered character |
| data_ready | output | 1 | A character is waiting |
| idle_flag | output | 1 | A full idle character followed traffic |
| overrun | output | 1 | A character was dropped because data was still waiting |
| noise_err | output | 1 | Sample disagreement in the delivered character |
| frame_err | output | 1 | Stop bit of the delivered character was 0 |
| sleeping | output | 1 | Receiver is asleep |

## Verification
The bench uses the default parameters: OVS=16, DATA_BITS=8 and SYNC_STAGES=2. Both frame lengths are selected through `frame_ext`. It raises the RT tick every fourth clock, so the two-flop synchronizer has settled before each sample. The bench can then drive the line one RT slot at a time and force single bad samples at RT9. It can also count the idle-line wakeup window exactly: the receiver must still be asleep after 159 or 175 high slots and awake after the next slot.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;

   typedef enum logic {
      RX_HUNT = 1'b0,
      RX_RECV = 1'b1
   } rx_state_e;

   function automatic logic vote3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

   function automatic logic split3(input logic a, input logic b, input logic c);
      return !((a == b) && (b == c));
   endfunction

endpackage

// File: rtl/mdrop_rx_sync.sv
module mdrop_rx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               r <= '1;
            end else begin
               r[0] <= d;
               for (int i = 1; i < int'(STAGES); i++) r[i] <= r[i-1];
            end
         end
         assign q = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/mdrop_rx_frame.sv
module mdrop_rx_frame
   import mdrop_rx_pkg::*;
#(
   parameter int unsigned OVS       = 16,
   parameter int unsigned DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 line,
   input  logic                 ext,
   output logic                 done,
   output logic [DATA_BITS:0]   data,
   output logic                 noisy,
   output logic                 ferr
);
   localparam int unsigned W  = DATA_BITS + 1;
   localparam int unsigned PW = $clog2(OVS + 1);
   localparam int unsigned BW = $clog2(DATA_BITS + 4);
   localparam int unsigned V1 = OVS / 2;
   localparam int unsigned V2 = V1 + 1;
   localparam int unsigned V3 = V1 + 2;

   rx_state_e         state;
   logic [PW-1:0]     rt;
   logic [PW-1:0]     cur_rt;
   logic [BW-1:0]     bidx;
   logic [BW-1:0]     last_data;
   logic [W-1:0]      shreg;
   logic              s_a, s_b, prev_hi, nacc;
   logic              v, dis;

   always_comb begin
      cur_rt    = (rt == PW'(OVS)) ? PW'(1) : rt + PW'(1);
      last_data = BW'(DATA_BITS) + BW'(ext);
      v         = vote3(s_a, s_b, line);
      dis       = split3(s_a, s_b, line);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RX_HUNT;
         rt      <= '0;
         bidx    <= '0;
         shreg   <= '0;
         s_a     <= 1'b1;
         s_b     <= 1'b1;
         prev_hi <= 1'b0;
         nacc    <= 1'b0;
         done    <= 1'b0;
         data    <= '0;
         noisy   <= 1'b0;
         ferr    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            prev_hi <= line;
            case (state)
               RX_HUNT: begin
                  if (prev_hi && !line) begin
                     state <= RX_RECV;
                     rt    <= PW'(1);
                     bidx  <= '0;
                     nacc  <= 1'b0;
                     shreg <= '0;
                  end
               end
               default: begin
                  rt <= cur_rt;
                  if (cur_rt == PW'(V1)) s_a <= line;
                  if (cur_rt == PW'(V2)) s_b <= line;
                  if (cur_rt == PW'(V3)) begin
                     bidx <= bidx + BW'(1);
                     if (bidx == '0) begin
                        nacc <= dis;
                        if (v) state <= RX_HUNT;
                     end else if (bidx <= last_data) begin
                        shreg <= {v, shreg[W-1:1]};
                        nacc  <= nacc | dis;
                     end else begin
                        done  <= 1'b1;
                        data  <= ext ? shreg : {1'b0, shreg[W-1:1]};
                        noisy <= nacc | dis;
                        ferr  <= !v;
                        state <= RX_HUNT;
                     end
                  end
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/mdrop_rx_idle.sv
module mdrop_rx_idle #(
   parameter int unsigned OVS       = 16,
   parameter int unsigned DATA_BITS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic line,
   input  logic ext,
   input  logic restart,
   output logic evt
);
   localparam int unsigned CW = $clog2((DATA_BITS + 3) * OVS + 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] thr;

   always_comb thr = CW'((DATA_BITS + 2) * OVS) + (ext ? CW'(OVS) : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         evt <= 1'b0;
      end else begin
         evt <= tick && line && !restart && (cnt == thr - CW'(1));
         if (restart) begin
            cnt <= '0;
         end else if (tick) begin
            if (!line)          cnt <= '0;
            else if (cnt < thr) cnt <= cnt + CW'(1);
         end
      end
   end
endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx #(
   parameter int unsigned OVS         = 16,
   parameter int unsigned DATA_BITS   = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rt_tick,
   input  logic                 rxd,
   input  logic                 frame_ext,
   input  logic                 wake_mark,
   input  logic                 sleep_req,
   input  logic                 read_ack,
   output logic [DATA_BITS:0]   rx_data,
   output logic                 data_ready,
   output logic                 idle_flag,
   output logic                 overrun,
   output logic                 noise_err,
   output logic                 frame_err,
   output logic                 sleeping
);
   generate
      if (OVS < 8) begin : g_bad_ovs
         $error("mdrop_rx: OVS must be at least 8");
      end
      if (DATA_BITS < 5 || DATA_BITS > 8) begin : g_bad_width
         $error("mdrop_rx: DATA_BITS must lie in 5..8");
      end
   endgenerate

   logic               line_s;
   logic               char_done;
   logic [DATA_BITS:0] char_data;
   logic               char_noisy, char_ferr;
   logic               idle_evt;
   logic               msb, addr_wake, idle_wake, accept, full_after_read, armed;

   mdrop_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rxd), .q(line_s)
   );

   mdrop_rx_frame #(.OVS(OVS), .DATA_BITS(DATA_BITS)) u_frame (
      .clk(clk), .rst_n(rst_n), .tick(rt_tick), .line(line_s), .ext(frame_ext),
      .done(char_done), .data(char_data), .noisy(char_noisy), .ferr(char_ferr)
   );

   mdrop_rx_idle #(.OVS(OVS), .DATA_BITS(DATA_BITS)) u_idle (
      .clk(clk), .rst_n(rst_n), .tick(rt_tick), .line(line_s), .ext(frame_ext),
      .restart(sleep_req), .evt(idle_evt)
   );

   always_comb begin
      msb             = frame_ext ? char_data[DATA_BITS] : char_data[DATA_BITS-1];
      addr_wake       = sleeping && wake_mark && char_done && msb;
      idle_wake       = sleeping && !wake_mark && idle_evt;
      accept          = char_done && (!sleeping || addr_wake);
      full_after_read = data_ready && !read_ack;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sleeping   <= 1'b0;
         rx_data    <= '0;
         data_ready <= 1'b0;
         idle_flag  <= 1'b0;
         overrun    <= 1'b0;
         noise_err  <= 1'b0;
         frame_err  <= 1'b0;
         armed      <= 1'b0;
      end else begin
         if (sleep_req)                   sleeping <= 1'b1;
         else if (addr_wake || idle_wake) sleeping <= 1'b0;

         if (read_ack) begin
            data_ready <= 1'b0;
            idle_flag  <= 1'b0;
            overrun    <= 1'b0;
            noise_err  <= 1'b0;
            frame_err  <= 1'b0;
         end

         if (idle_evt && !sleeping && armed) begin
            idle_flag <= 1'b1;
            armed     <= 1'b0;
         end

         if (accept) begin
            armed <= 1'b1;
            if (full_after_read) begin
               overrun <= 1'b1;
            end else begin
               rx_data    <= char_data;
               data_ready <= 1'b1;
               noise_err  <= char_noisy;
               frame_err  <= char_ferr;
            end
         end
      end
   end
endmodule

// File: rtl/mdrop_rx_chk.sv
module mdrop_rx_chk #(
   parameter int unsigned DATA_BITS = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sleep_req,
   input logic               sleeping,
   input logic               data_ready,
   input logic               idle_flag,
   input logic               overrun,
   input logic               noise_err,
   input logic               frame_err,
   input logic [DATA_BITS:0] rx_data,
   input logic               char_done,
   input logic               idle_evt
);
   a_r9_quiet_asleep: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sleeping) && sleeping) |-> !($rose(data_ready) || $rose(idle_flag) ||
         $rose(overrun) || $rose(noise_err) || $rose(frame_err)));

   a_r9_sleep_set: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_req |=> sleeping);

   a_r6_overrun_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(data_ready));

   a_r6_overrun_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $stable(rx_data));

   a_r2_ready_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_ready) |-> $past(char_done));

   a_r8_idle_from_detector: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(idle_flag) |-> $past(idle_evt));

   a_r5_ferr_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> data_ready);

   a_r4_noise_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
      noise_err |-> data_ready);
endmodule

bind mdrop_rx mdrop_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleeping(sleeping),
   .data_ready(data_ready), .idle_flag(idle_flag), .overrun(overrun),
   .noise_err(noise_err), .frame_err(frame_err), .rx_data(rx_data),
   .char_done(char_done), .idle_evt(idle_evt)
);

// File: tb/mdrop_rx_test.sv
module mdrop_rx_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rt_tick = 1'b0;
   logic       rxd = 1'b1;
   logic       frame_ext = 1'b0;
   logic       wake_mark = 1'b0;
   logic       sleep_req = 1'b0;
   logic       read_ack = 1'b0;
   logic [8:0] rx_data;
   logic       data_ready, idle_flag, overrun, noise_err, frame_err, sleeping;

   int checks = 0;
   int fails  = 0;
   int tcnt   = 0;

   mdrop_rx uut (
      .clk(clk), .rst_n(rst_n), .rt_tick(rt_tick), .rxd(rxd), .frame_ext(frame_ext),
      .wake_mark(wake_mark), .sleep_req(sleep_req), .read_ack(read_ack),
      .rx_data(rx_data), .data_ready(data_ready), .idle_flag(idle_flag),
      .overrun(overrun), .noise_err(noise_err), .frame_err(frame_err),
      .sleeping(sleeping)
   );

   always #4 clk = ~clk;

   always @(negedge clk) begin
      tcnt    <= (tcnt == 3) ? 0 : tcnt + 1;
      rt_tick <= (tcnt == 3);
   end

   // {ext, data[8:0], stop, noisy bit index (15 = none)}
   localparam int NV = 7;
   localparam logic [14:0] VEC [NV] = '{
      {1'b0, 9'h055, 1'b1, 4'd15},
      {1'b0, 9'h0A3, 1'b1, 4'd3},
      {1'b1, 9'h1C6, 1'b1, 4'd15},
      {1'b1, 9'h0F0, 1'b0, 4'd15},
      {1'b0, 9'h000, 1'b1, 4'd0},
      {1'b0, 9'h0FF, 1'b1, 4'd9},
      {1'b1, 9'h101, 1'b1, 4'd10}
   };

   task automatic check(input string what, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%0h exp=%0h", what, got, exp);
      end
   endtask

   task automatic rt_slot(input logic v);
      rxd = v;
      do @(posedge clk); while (rt_tick !== 1'b1);
   endtask

   task automatic idle_slots(input int n);
      for (int i = 0; i < n; i++) rt_slot(1'b1);
   endtask

   task automatic send_bit(input logic v, input logic bad);
      for (int r = 1; r <= 16; r++) rt_slot((bad && r == 9) ? !v : v);
   endtask

   task automatic send_frame(input logic ext, input logic [8:0] d, input logic stop,
                             input int noisy);
      idle_slots(2);
      send_bit(1'b0, noisy == 0);
      for (int i = 0; i < 8 + int'(ext); i++) send_bit(d[i], noisy == i + 1);
      send_bit(stop, noisy == 9 + int'(ext));
      idle_slots(4);
      @(negedge clk);
   endtask

   task automatic pulse_read();
      @(negedge clk) read_ack = 1'b1;
      @(negedge clk) read_ack = 1'b0;
   endtask

   task automatic pulse_sleep();
      @(negedge clk) sleep_req = 1'b1;
      @(negedge clk) sleep_req = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      // R12 reset state
      check("R12 rx_data", 16'(rx_data), 0);
      check("R12 flags", {10'd0, data_ready, idle_flag, overrun, noise_err, frame_err, sleeping}, 0);
      rst_n = 1'b1;

      // R8: idle after reset without a character gives no idle flag
      idle_slots(200);
      @(negedge clk);
      check("R8 no idle before any char", 16'(idle_flag), 0);

      // Vector walk: R1 R2 R4 R5 R7
      for (int k = 0; k < NV; k++) begin
         logic       e;
         logic [8:0] d;
         logic       st;
         int         nz;
         e  = VEC[k][14];
         d  = VEC[k][13:5];
         st = VEC[k][4];
         nz = int'(VEC[k][3:0]);
         frame_ext = e;
         send_frame(e, d, st, nz);
         check("R2 R1 data", 16'(rx_data), 16'(e ? d : {1'b0, d[7:0]}));
         check("R2 ready", 16'(data_ready), 1);
         check("R4 noise", 16'(noise_err), 16'(nz != 15));
         check("R5 framing", 16'(frame_err), 16'(!st));
         if (!st) idle_slots(20);
         pulse_read();
         @(negedge clk);
         check("R7 cleared", {12'd0, data_ready, noise_err, frame_err, overrun}, 0);
      end
      frame_ext = 1'b0;

      // R8: idle flag once after traffic
      idle_slots(200);
      @(negedge clk);
      check("R8 idle after char", 16'(idle_flag), 1);
      pulse_read();
      @(negedge clk);
      check("R7 idle cleared", 16'(idle_flag), 0);
      idle_slots(200);
      @(negedge clk);
      check("R8 idle not repeated", 16'(idle_flag), 0);

      // R3: short low glitch, voted start is high
      for (int i = 0; i < 5; i++) rt_slot(1'b0);
      idle_slots(60);
      @(negedge clk);
      check("R3 false start", 16'(data_ready), 0);

      // R6 overrun
      send_frame(1'b0, 9'h011, 1'b1, 15);
      send_frame(1'b0, 9'h022, 1'b1, 15);
      check("R6 overrun", 16'(overrun), 1);
      check("R6 keeps old data", 16'(rx_data), 16'h011);
      pulse_read();
      @(negedge clk);
      check("R7 overrun cleared", 16'(overrun), 0);

      // R11 address mark, 8-bit
      wake_mark = 1'b1;
      pulse_sleep();
      @(negedge clk);
      check("R9 sleeping set", 16'(sleeping), 1);
      send_frame(1'b0, 9'h005, 1'b0, 4);
      idle_slots(20);
      @(negedge clk);
      check("R9 R11 quiet while asleep", {13'd0, data_ready, noise_err, frame_err}, 0);
      check("R11 still asleep", 16'(sleeping), 1);
      send_frame(1'b0, 9'h085, 1'b1, 15);
      check("R11 woke", 16'(sleeping), 0);
      check("R11 address delivered", {6'd0, data_ready, rx_data}, {6'd0, 1'b1, 9'h085});
      pulse_read();

      // R11 address mark, 9-bit
      frame_ext = 1'b1;
      pulse_sleep();
      send_frame(1'b1, 9'h080, 1'b1, 15);
      check("R11 9-bit bit7 ignored", {14'd0, sleeping, data_ready}, 16'h2);
      send_frame(1'b1, 9'h100, 1'b1, 15);
      check("R11 9-bit woke", {6'd0, sleeping, rx_data}, {6'd0, 1'b0, 9'h100});
      pulse_read();

      // R10 idle-line wakeup, 8-bit
      frame_ext = 1'b0;
      wake_mark = 1'b0;
      idle_slots(4);
      pulse_read();
      pulse_sleep();
      idle_slots(159);
      @(negedge clk);
      check("R10 asleep at 159", 16'(sleeping), 1);
      idle_slots(1);
      repeat (3) @(negedge clk);
      check("R10 awake at 160", {14'd0, sleeping, idle_flag}, 0);

      // R11 in idle-line mode: address char dropped while asleep
      pulse_sleep();
      send_frame(1'b0, 9'h080, 1'b1, 15);
      check("R11 idle mode drops char", {14'd0, sleeping, data_ready}, 16'h2);

      // R10 idle-line wakeup, 9-bit
      frame_ext = 1'b1;
      pulse_sleep();
      idle_slots(175);
      @(negedge clk);
      check("R10 9-bit asleep at 175", 16'(sleeping), 1);
      idle_slots(1);
      repeat (3) @(negedge clk);
      check("R10 9-bit awake at 176", 16'(sleeping), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule